// File: doc/BRIEF.md
# Loadable Synchronous Up-Counter

This block is a small binary up-counter, four bits wide by default, whose state changes only on the rising edge of its clock. On each edge it does exactly one of four things: it returns to zero, it takes a new value from a parallel data bus, it steps up by one, or it holds its value. Two separate enables gate the stepping. Both must be high for the count to advance, so a host can freeze the counter from either side.

A terminal-count carry output goes high while the register holds its all-ones value and the chaining enable is high. Several units can therefore be joined into a wider counter. The carry of one stage drives an enable of the next stage. Any chain built this way stays fully synchronous. The chaining itself is done outside this block.

Top module: `sync_load_counter`

## Requirements
- R1: When `clr_n` is low at a rising clock edge, `count` becomes 0 after that edge, whatever `ld_n`, `cnt_en`, `chain_en` and `din` are.
- R2: When `clr_n` and `ld_n` are both low at the same edge, the clear wins and `count` becomes 0, not `din`.
- R3: When `clr_n` is high and `ld_n` is low at an edge, `count` takes the value of `din` after that edge, whatever the two enables are.
- R4: When `clr_n` and `ld_n` are high and both `cnt_en` and `chain_en` are high at an edge, `count` increases by exactly one.
- R5: When `clr_n` and `ld_n` are high and either enable is low at an edge, `count` keeps its value.
- R6: Counting from the all-ones value (15 at the default width) wraps to 0, and the count then goes on 1, 2, and so on.
- R7: `carry_out` is 1 exactly when `count` is all ones and `chain_en` is high. It follows `chain_en` combinationally, without waiting for a clock edge.
- R8: Clear and load are synchronous. A change on `clr_n`, `ld_n` or `din` between clock edges leaves `count` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable, must be high to advance |
| chain_en | input | 1 | Second count enable; also gates the carry output |
| din | input | WIDTH (4) | Parallel load value |
| count | output | WIDTH (4) | Current count |
| carry_out | output | 1 | High when count is all ones and chain_en is high |

## Verification
The bench applies clear and load together, and a design with the wrong priority would land on the load value instead of zero. It loads with both enables high, where a design that lets counting win would show the load value plus one. It counts through the all-ones value, where a design that saturates or skips would not show 0 after 15. It drops `chain_en` while the count sits at 15, and a design whose carry ignores the enable would still show carry high.

Clear and load are also asserted between edges. The count is sampled before the next edge, so an asynchronous clear or load would show up as an early change. Each enable is held low on its own, so a design that needs only one of them to count would advance when it should hold.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    // Action the counter register takes on the next rising edge.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } ctr_op_e;

endpackage

// File: rtl/ctr_ctrl.sv
module ctr_ctrl
    import ctr_pkg::*;
(
    input  logic    clr_n,
    input  logic    ld_n,
    input  logic    cnt_en,
    input  logic    chain_en,
    output ctr_op_e op
);

    // Fixed priority: clear, then load, then count, else hold.
    always_comb begin
        if (!clr_n) begin
            op = OP_CLEAR;
        end else if (!ld_n) begin
            op = OP_LOAD;
        end else if (cnt_en && chain_en) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/ctr_core.sv
module ctr_core
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  ctr_op_e          op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             armed
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } core_state_t;

    core_state_t state_d, state_q;

    // Set once the first clear has been seen, so the checks ignore power-up state.
    logic armed_q = 1'b0;

    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_CLEAR: state_d.count = '0;
            OP_LOAD:  state_d.count = din;
            OP_COUNT: state_d.count = state_q.count + ONE;
            default:  state_d.count = state_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
        armed_q <= armed_q | (op == OP_CLEAR);
    end

    assign count = state_q.count;
    assign armed = armed_q;

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (op == OP_CLEAR) |=> (count == '0));

    // R3
    load_value_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (op == OP_LOAD) |=> (count == $past(din)));

    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (op == OP_COUNT && $past(armed_q)) |=> (count == WIDTH'($past(count) + ONE)));

    // R5
    hold_still_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (op == OP_HOLD) |=> $stable(count));

    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (op == OP_COUNT && count == ALL_ONES) |=> (count == '0));

endmodule

// File: rtl/ctr_carry.sv
module ctr_carry #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             armed,
    input  logic [WIDTH-1:0] count,
    input  logic             chain_en,
    output logic             carry_out
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic at_top;

    always_comb begin
        at_top    = (count == ALL_ONES);
        carry_out = at_top & chain_en;
    end

    // R7
    carry_gate_chk: assert property (@(posedge clk) disable iff (!armed)
        carry_out |-> (chain_en && $countones(count) == WIDTH));

endmodule

// File: rtl/sync_load_counter.sv
module sync_load_counter
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             ld_n,
    input  logic             cnt_en,
    input  logic             chain_en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             carry_out
);

    ctr_op_e op;
    logic    armed;

    ctr_ctrl u_ctrl (
        .clr_n    (clr_n),
        .ld_n     (ld_n),
        .cnt_en   (cnt_en),
        .chain_en (chain_en),
        .op       (op)
    );

    ctr_core #(.WIDTH(WIDTH)) u_core (
        .clk   (clk),
        .op    (op),
        .din   (din),
        .count (count),
        .armed (armed)
    );

    ctr_carry #(.WIDTH(WIDTH)) u_carry (
        .clk       (clk),
        .armed     (armed),
        .count     (count),
        .chain_en  (chain_en),
        .carry_out (carry_out)
    );

endmodule

// File: tb/sync_load_counter_tb.sv
module sync_load_counter_tb;

    logic       clk = 1'b0;
    logic       clr_n = 1'b1;
    logic       ld_n = 1'b1;
    logic       cnt_en = 1'b0;
    logic       chain_en = 1'b0;
    logic [3:0] din = 4'd0;
    logic [3:0] count;
    logic       carry_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sync_load_counter #(.WIDTH(4)) u_dut (
        .clk       (clk),
        .clr_n     (clr_n),
        .ld_n      (ld_n),
        .cnt_en    (cnt_en),
        .chain_en  (chain_en),
        .din       (din),
        .count     (count),
        .carry_out (carry_out)
    );

    // Vector fields: {clr_n, ld_n, cnt_en, chain_en, din[3:0], exp_count[3:0], exp_carry}
    localparam int NVEC = 15;
    localparam logic [12:0] VEC [NVEC] = '{
        {4'b0111, 4'd5,  4'd0,  1'b0},  // clear
        {4'b1111, 4'd0,  4'd1,  1'b0},  // count
        {4'b1111, 4'd0,  4'd2,  1'b0},  // count
        {4'b1101, 4'd0,  4'd2,  1'b0},  // cnt_en low: hold
        {4'b1110, 4'd0,  4'd2,  1'b0},  // chain_en low: hold
        {4'b1000, 4'd13, 4'd13, 1'b0},  // load, enables low
        {4'b1111, 4'd0,  4'd14, 1'b0},  // count
        {4'b1111, 4'd0,  4'd15, 1'b1},  // count to top, carry
        {4'b1110, 4'd0,  4'd15, 1'b0},  // hold, carry masked
        {4'b1101, 4'd0,  4'd15, 1'b1},  // hold, carry shown
        {4'b1111, 4'd0,  4'd0,  1'b0},  // wrap
        {4'b0011, 4'd10, 4'd0,  1'b0},  // clear beats load
        {4'b1011, 4'd7,  4'd7,  1'b0},  // load beats count
        {4'b1111, 4'd0,  4'd8,  1'b0},  // count
        {4'b0111, 4'd0,  4'd0,  1'b0}   // clear with enables
    };

    task automatic check_count(input logic [3:0] exp, input string req);
        checks++;
        if (count !== exp) begin
            errors++;
            $display("FAIL %s count actual=%0d expected=%0d", req, count, exp);
        end
    endtask

    task automatic check_carry(input logic exp, input string req);
        checks++;
        if (carry_out !== exp) begin
            errors++;
            $display("FAIL %s carry_out actual=%0b expected=%0b", req, carry_out, exp);
        end
    endtask

    task automatic drive(input logic c, input logic l, input logic p, input logic t,
                         input logic [3:0] d);
        @(negedge clk);
        clr_n    = c;
        ld_n     = l;
        cnt_en   = p;
        chain_en = t;
        din      = d;
        @(posedge clk);
        #1;
    endtask

    function automatic string tag_of(input logic c, input logic l, input logic p,
                                     input logic t, input logic [3:0] e);
        if (!c && !l) return "R2";
        if (!c) return "R1";
        if (!l) return "R3";
        if (p && t) return (e == 4'd0) ? "R6" : "R4";
        return "R5";
    endfunction

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Reset state via synchronous clear (R1)
        drive(1'b0, 1'b1, 1'b0, 1'b0, 4'd9);
        check_count(4'd0, "R1");
        check_carry(1'b0, "R7");

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [12:0] v;
            v = VEC[i];
            drive(v[12], v[11], v[10], v[9], v[8:5]);
            check_count(v[4:1], tag_of(v[12], v[11], v[10], v[9], v[4:1]));
            check_carry(v[0], "R7");
        end

        // R8: clear applied between edges has no effect until the edge
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd6);
        check_count(4'd6, "R3");
        @(negedge clk);
        clr_n = 1'b0;
        #1;
        check_count(4'd6, "R8");
        @(posedge clk);
        #1;
        check_count(4'd0, "R8");

        // R8: load and din changed between edges
        drive(1'b1, 1'b1, 1'b0, 1'b0, 4'd0);
        @(negedge clk);
        ld_n = 1'b0;
        din  = 4'd11;
        #1;
        check_count(4'd0, "R8");
        @(posedge clk);
        #1;
        check_count(4'd11, "R3");

        // R7: carry follows chain_en without a clock edge
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd15);
        @(negedge clk);
        ld_n     = 1'b1;
        chain_en = 1'b1;
        #0.5;
        check_carry(1'b1, "R7");
        chain_en = 1'b0;
        #0.5;
        check_carry(1'b0, "R7");

        // R4, R6, R7: full cycle from 0 through the wrap
        drive(1'b0, 1'b1, 1'b1, 1'b1, 4'd0);
        check_count(4'd0, "R1");
        for (int k = 1; k <= 17; k++) begin
            drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
            check_count(4'(k), (k % 16 == 0) ? "R6" : "R4");
            check_carry((4'(k) == 4'd15), "R7");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule